// File: doc/BRIEF.md
# Statically Routed Word Switch with Credit Flow Control

This block is the switch inside one tile of a word-stream mesh network. Streams carry bare data words with no header and no framing, so the route a word takes comes from a stored map and not from the data. For every output port, the map names the input port that feeds it and whether that route is enabled. Several outputs may name the same input, and one word is then copied to all of them in the same cycle. The map is loaded with a single write strobe and stays in force until the next write.

Each outgoing link is throttled by a credit counter. The counter starts at the depth of the neighbour's receive buffer, which is three words. A word uses one credit. The neighbour returns one credit by pulsing an acknowledge each time it removes a word from its buffer. On the receive side, every input has its own three-word buffer, and the switch sends the same kind of acknowledge pulse upstream for every word it consumes. A protection bit on each output blocks the enabled routes that target that port. A word that would have crossed a protected port is not sent there, and a sticky interrupt flag is set.

Top module: `sw_static_xbar`

## Requirements
- R1: While reset is asserted and after its release, no output is valid, no acknowledge is sent upstream, the interrupt flag is clear, and every route is disabled.
- R2: The route map, the enable bits and the protection bits are captured only in a cycle where `cfg_we` is high. Changing the configuration inputs while `cfg_we` is low has no effect on where words go.
- R3: A word captured on input i at one clock edge appears at every output routed from i on the following edge. Words on each route come out in the order they went in, and one word per clock can flow.
- R4: When several outputs select the same input, a word from that input is presented on all of those outputs in the same cycle, with identical data.
- R5: Each output credit counter starts at 3 after reset. An output never sends while its count is zero. Each pulse on its `out_ack` bit gives back exactly one credit.
- R6: An input's head word is removed only in a cycle where every enabled, unprotected output that selects that input holds a credit. Otherwise none of those outputs sends.
- R7: `in_ack[i]` pulses for exactly one cycle for every word removed from input i's buffer. It pulses on the edge where the word leaves.
- R8: A protected output never sends. The other selected outputs still get the word. If only protected outputs select an input, that input's words are consumed and acknowledged but are not sent anywhere.
- R9: `wall_irq` is set when a word is consumed while a protected route selects its input. It stays set until reset or the next configuration write, and a configuration write clears it.
- R10: Each input buffers up to three words while its outputs are stalled. No word is lost, and no word is reordered.
- R11: Words on an input that no enabled route selects stay buffered and are not acknowledged. They flow once a route is configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Loads the three configuration buses |
| cfg_src | input | NPORTS*SELW | Source input index for each output, SELW bits per output, with output o at bits o*SELW and up |
| cfg_en | input | NPORTS | Route enable per output |
| cfg_wall | input | NPORTS | Protection bit per output |
| in_valid | input | NPORTS | Word present on each input link |
| in_data | input | NPORTS*DW | Input words, with input i at bits i*DW and up |
| in_ack | output | NPORTS | Credit return to each upstream sender |
| out_valid | output | NPORTS | Word present on each output link |
| out_data | output | NPORTS*DW | Output words, with output o at bits o*DW and up |
| out_ack | input | NPORTS | Credit return from each downstream receiver |
| wall_irq | output | 1 | Sticky protection-violation flag |

## Verification
The bench drains one output's credits and then releases them one at a time. A counter that wraps below zero, or that ignores acknowledges, would send extra words or freeze. A multicast is routed through one starved output and one free output; a design that lets the free branch go ahead alone would duplicate or drop the word on the starved branch. Protected routes are tested both with an unprotected sibling and on their own, which exposes a design that leaks words through the protected port, stalls the input forever, or loses the sticky flag. Words are also parked on an unrouted input, and configuration buses are wiggled without the strobe, to catch premature consumption and configuration that takes effect without the strobe.

// File: rtl/sw_xbar_pkg.sv
package sw_xbar_pkg;
  localparam int PORT_COUNT = 5;
  typedef enum logic [2:0] {
    DIR_NORTH = 3'd0,
    DIR_EAST  = 3'd1,
    DIR_SOUTH = 3'd2,
    DIR_WEST  = 3'd3,
    DIR_LOCAL = 3'd4
  } dir_e;
endpackage

// File: rtl/sw_in_fifo.sv
module sw_in_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic          empty,
  output logic [DW-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop  = pop && (cnt != '0);
  assign do_push = push && ((cnt != CW'(DEPTH)) || do_pop);
  assign empty   = (cnt == '0);
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sw_credit_ctr.sv
module sw_credit_ctr #(
  parameter int CREDITS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic give,
  output logic avail
);
  localparam int CW = $clog2(CREDITS + 1);

  logic [CW-1:0] cnt;

  assign avail = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CW'(CREDITS);
    end else begin
      case ({take, give})
        2'b10:   cnt <= cnt - 1'b1;
        2'b01:   cnt <= cnt + 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sw_static_xbar.sv
module sw_static_xbar
  import sw_xbar_pkg::*;
#(
  parameter int NPORTS  = PORT_COUNT,
  parameter int DW      = 32,
  parameter int CREDITS = 3,
  parameter int DEPTH   = 3,
  parameter int SELW    = $clog2(NPORTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [NPORTS*SELW-1:0] cfg_src,
  input  logic [NPORTS-1:0]      cfg_en,
  input  logic [NPORTS-1:0]      cfg_wall,
  input  logic [NPORTS-1:0]      in_valid,
  input  logic [NPORTS*DW-1:0]   in_data,
  output logic [NPORTS-1:0]      in_ack,
  output logic [NPORTS-1:0]      out_valid,
  output logic [NPORTS*DW-1:0]   out_data,
  input  logic [NPORTS-1:0]      out_ack,
  output logic                   wall_irq
);
  // stored configuration
  logic [NPORTS*SELW-1:0] src_q;
  logic [NPORTS-1:0]      en_q, wall_q;
  logic [SELW-1:0]        src_of [NPORTS];

  // per-port datapath signals
  logic [DW-1:0]     head [NPORTS];
  logic [DW-1:0]     mux  [NPORTS];
  logic [NPORTS-1:0] emp, has_word, cr_ok;
  logic [NPORTS-1:0] refd, blk, whit, pop, hit, send;

  // registered outputs
  logic [NPORTS-1:0]    out_valid_q, in_ack_q;
  logic [NPORTS*DW-1:0] out_data_q;
  logic                 irq_q;

  genvar g;
  generate
    for (g = 0; g < NPORTS; g++) begin : g_port
      assign src_of[g]   = src_q[g*SELW +: SELW];
      assign has_word[g] = ~emp[g];

      sw_in_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (in_valid[g]),
        .din   (in_data[g*DW +: DW]),
        .pop   (pop[g]),
        .empty (emp[g]),
        .dout  (head[g])
      );

      sw_credit_ctr #(.CREDITS(CREDITS)) u_cred (
        .clk   (clk),
        .rst   (rst),
        .take  (send[g]),
        .give  (out_ack[g]),
        .avail (cr_ok[g])
      );
    end
  endgenerate

  // Input side: find out whether each input is referenced, stalled or hits a wall.
  always_comb begin
    refd = '0;
    blk  = '0;
    whit = '0;
    for (int o = 0; o < NPORTS; o++) begin
      for (int i = 0; i < NPORTS; i++) begin
        if (en_q[o] && (src_of[o] == SELW'(i))) begin
          refd[i] = 1'b1;
          if (wall_q[o])       whit[i] = 1'b1;
          else if (!cr_ok[o])  blk[i]  = 1'b1;
        end
      end
    end
  end

  assign pop = has_word & refd & ~blk;
  assign hit = pop & whit;

  // Output side: select data and fire every live route whose source pops.
  always_comb begin
    for (int o = 0; o < NPORTS; o++) begin
      send[o] = 1'b0;
      mux[o]  = '0;
      for (int i = 0; i < NPORTS; i++) begin
        if (src_of[o] == SELW'(i)) begin
          mux[o]  = head[i];
          send[o] = en_q[o] & ~wall_q[o] & pop[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      en_q   <= '0;
      wall_q <= '0;
    end else if (cfg_we) begin
      src_q  <= cfg_src;
      en_q   <= cfg_en;
      wall_q <= cfg_wall;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= '0;
      in_ack_q    <= '0;
      irq_q       <= 1'b0;
    end else begin
      out_valid_q <= send;
      in_ack_q    <= pop;
      if (cfg_we)    irq_q <= 1'b0;
      else if (|hit) irq_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < NPORTS; o++) begin
      if (send[o]) out_data_q[o*DW +: DW] <= mux[o];
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign in_ack    = in_ack_q;
  assign wall_irq  = irq_q;
endmodule

// File: rtl/sw_static_xbar_chk.sv
module sw_static_xbar_chk #(
  parameter int NPORTS  = 5,
  parameter int CREDITS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [NPORTS-1:0] in_valid,
  input logic [NPORTS-1:0] in_ack,
  input logic [NPORTS-1:0] out_valid,
  input logic [NPORTS-1:0] out_ack,
  input logic [NPORTS-1:0] wall_q,
  input logic              wall_irq
);
  int occ [NPORTS];
  int crd [NPORTS];

  genvar g;
  generate
    for (g = 0; g < NPORTS; g++) begin : g_chk
      always_ff @(posedge clk) begin
        if (rst) begin
          occ[g] <= 0;
          crd[g] <= CREDITS;
        end else begin
          occ[g] <= occ[g] + int'(in_valid[g]) - int'(in_ack[g]);
          crd[g] <= crd[g] - int'(out_valid[g]) + int'(out_ack[g]);
        end
      end

      AST_ACK_HAS_WORD: assert property (@(posedge clk) disable iff (rst)
        in_ack[g] |-> (occ[g] > 0)); // R7
      AST_SEND_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (rst)
        out_valid[g] |-> (crd[g] > 0)); // R5
      AST_CREDIT_CEILING: assert property (@(posedge clk) disable iff (rst)
        crd[g] <= CREDITS); // R5
      AST_WALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        out_valid[g] |-> !$past(wall_q[g])); // R8
    end
  endgenerate

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(wall_irq) && !$past(cfg_we)) |-> wall_irq); // R9
  AST_IRQ_CLEARED_BY_CFG: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !wall_irq); // R9
endmodule

bind sw_static_xbar sw_static_xbar_chk #(.NPORTS(NPORTS), .CREDITS(CREDITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .in_valid  (in_valid),
  .in_ack    (in_ack),
  .out_valid (out_valid),
  .out_ack   (out_ack),
  .wall_q    (wall_q),
  .wall_irq  (wall_irq)
);

// File: tb/sw_static_xbar_tb.sv
module sw_static_xbar_tb;
  import sw_xbar_pkg::*;
  localparam int NP = 5;
  localparam int DW = 32;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [NP*SW-1:0] cfg_src = '0;
  logic [NP-1:0] cfg_en = '0, cfg_wall = '0;
  logic [NP-1:0] in_valid = '0;
  logic [NP*DW-1:0] in_data = '0;
  logic [NP-1:0] in_ack, out_valid, out_ack;
  logic [NP*DW-1:0] out_data;
  logic wall_irq;
  logic [NP-1:0] auto_ack = '0, auto_pulse = '0, man_ack = '0;

  assign out_ack = auto_pulse | man_ack;

  always #10 clk = ~clk;

  sw_static_xbar u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_en(cfg_en),
    .cfg_wall(cfg_wall), .in_valid(in_valid), .in_data(in_data), .in_ack(in_ack),
    .out_valid(out_valid), .out_data(out_data), .out_ack(out_ack), .wall_irq(wall_irq)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_src [NP];
  bit m_en [NP], m_wall [NP];
  logic [DW-1:0] exp_q [NP][$];
  int cnt_out [NP];
  int cnt_ack [NP];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor, sampling mid-high phase
  always @(posedge clk) begin
    #5;
    for (int o = 0; o < NP; o++) begin
      auto_pulse[o] = 1'b0;
      if (!rst && out_valid[o]) begin
        cnt_out[o]++;
        auto_pulse[o] = auto_ack[o];
        checks++;
        if (exp_q[o].size() == 0) begin
          errors++;
          $display("FAIL R3 unexpected word on out%0d: actual %h expected none", o, out_data[o*DW +: DW]);
        end else begin
          logic [DW-1:0] e;
          e = exp_q[o].pop_front();
          if (out_data[o*DW +: DW] !== e) begin
            errors++;
            $display("FAIL R3 out%0d data: actual %h expected %h", o, out_data[o*DW +: DW], e);
          end
        end
      end
      if (!rst && in_ack[o]) cnt_ack[o]++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_cfg(input bit strobe);
    for (int o = 0; o < NP; o++) begin
      cfg_src[o*SW +: SW] = SW'(m_src[o]);
      cfg_en[o]   = m_en[o];
      cfg_wall[o] = m_wall[o];
    end
    cfg_we = strobe;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic clear_model();
    for (int o = 0; o < NP; o++) begin
      m_src[o] = 0; m_en[o] = 1'b0; m_wall[o] = 1'b0;
    end
  endtask

  task automatic send_word(input int i, input logic [DW-1:0] d);
    in_valid[i] = 1'b1;
    in_data[i*DW +: DW] = d;
    for (int o = 0; o < NP; o++)
      if (m_en[o] && !m_wall[o] && m_src[o] == i) exp_q[o].push_back(d);
    tick(1);
    in_valid[i] = 1'b0;
  endtask

  task automatic give_ack(input int o);
    man_ack[o] = 1'b1;
    tick(1);
    man_ack[o] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int b0, b1, b2;
    for (int o = 0; o < NP; o++) begin cnt_out[o] = 0; cnt_ack[o] = 0; end
    clear_model();
    tick(4);
    chk(out_valid == '0 && in_ack == '0 && wall_irq == 1'b0, "R1", "outputs in reset",
        int'(out_valid), 0);
    rst = 1'b0;
    tick(3);
    chk(out_valid == '0 && wall_irq == 1'b0, "R1", "idle after reset", int'(out_valid), 0);
    // no route enabled after reset: a word on input 0 must stay parked
    send_word(0, 32'hDEAD0000);
    tick(4);
    chk(cnt_ack[0] == 0, "R1", "no route after reset, in_ack count", cnt_ack[0], 0);
    chk(cnt_out[0] + cnt_out[1] + cnt_out[2] + cnt_out[3] + cnt_out[4] == 0, "R1",
        "no output after reset", cnt_out[0], 0);

    // R3: unicast stream west -> east; the parked word from input 0 goes to out4
    m_src[DIR_EAST] = int'(DIR_WEST); m_en[DIR_EAST] = 1'b1;
    m_src[DIR_LOCAL] = int'(DIR_NORTH); m_en[DIR_LOCAL] = 1'b1;
    auto_ack = '1;
    exp_q[DIR_LOCAL].push_back(32'hDEAD0000);
    drive_cfg(1'b1);
    for (int k = 0; k < 4; k++) send_word(int'(DIR_WEST), 32'hA000 + k);
    tick(5);
    chk(cnt_out[DIR_EAST] == 4, "R3", "unicast words delivered", cnt_out[DIR_EAST], 4);
    chk(cnt_ack[DIR_WEST] == 4, "R7", "one in_ack per consumed word", cnt_ack[DIR_WEST], 4);
    chk(cnt_out[DIR_LOCAL] == 1, "R11", "parked word released by route", cnt_out[DIR_LOCAL], 1);

    // R2: bus changes without the strobe do not take effect
    b1 = cnt_out[DIR_EAST]; b2 = cnt_out[DIR_SOUTH];
    cfg_src[DIR_SOUTH*SW +: SW] = SW'(DIR_WEST); cfg_en = 5'b00100;
    tick(1);
    send_word(int'(DIR_WEST), 32'hB0B0);
    tick(4);
    chk(cnt_out[DIR_EAST] == b1 + 1, "R2", "old route still used", cnt_out[DIR_EAST], b1 + 1);
    chk(cnt_out[DIR_SOUTH] == b2, "R2", "unstrobed route unused", cnt_out[DIR_SOUTH], b2);

    // R4: multicast from local to outputs 0,1,2
    clear_model();
    for (int o = 0; o < 3; o++) begin m_src[o] = int'(DIR_LOCAL); m_en[o] = 1'b1; end
    drive_cfg(1'b1);
    send_word(int'(DIR_LOCAL), 32'hC0FFEE01);
    tick(1);
    chk(out_valid[2:0] == 3'b111, "R4", "multicast same cycle", int'(out_valid[2:0]), 7);
    for (int k = 0; k < 3; k++) send_word(int'(DIR_LOCAL), 32'hC100 + k);
    tick(5);

    // R5: credits on output 0 without acks
    clear_model();
    m_src[0] = int'(DIR_EAST); m_en[0] = 1'b1;
    auto_ack[0] = 1'b0;
    drive_cfg(1'b1);
    b0 = cnt_out[0];
    for (int k = 0; k < 5; k++) send_word(int'(DIR_EAST), 32'hD000 + k);
    tick(8);
    chk(cnt_out[0] == b0 + 3, "R5", "sends stop at zero credit", cnt_out[0] - b0, 3);
    give_ack(0);
    tick(4);
    chk(cnt_out[0] == b0 + 4, "R5", "one ack releases one word", cnt_out[0] - b0, 4);
    give_ack(0);
    tick(4);
    chk(cnt_out[0] == b0 + 5, "R10", "buffered words all delivered", cnt_out[0] - b0, 5);

    // R6: multicast waits for the starved branch
    m_src[2] = int'(DIR_EAST); m_en[2] = 1'b1;
    drive_cfg(1'b1);
    b0 = cnt_out[0]; b2 = cnt_out[2]; b1 = cnt_ack[DIR_EAST];
    send_word(int'(DIR_EAST), 32'hE6E6);
    tick(5);
    chk(cnt_out[2] == b2, "R6", "free branch held back", cnt_out[2] - b2, 0);
    chk(cnt_ack[DIR_EAST] == b1, "R6", "input not consumed", cnt_ack[DIR_EAST] - b1, 0);
    give_ack(0);
    tick(4);
    chk(cnt_out[0] == b0 + 1 && cnt_out[2] == b2 + 1, "R6", "both branches after credit",
        cnt_out[0] + cnt_out[2] - b0 - b2, 2);
    for (int k = 0; k < 3; k++) give_ack(0);
    auto_ack[0] = 1'b1;

    // R8/R9: protected port with unprotected sibling
    clear_model();
    m_src[1] = int'(DIR_NORTH); m_en[1] = 1'b1;
    m_src[3] = int'(DIR_NORTH); m_en[3] = 1'b1; m_wall[3] = 1'b1;
    drive_cfg(1'b1);
    chk(wall_irq == 1'b0, "R9", "flag clear after config", int'(wall_irq), 0);
    b1 = cnt_out[1]; b2 = cnt_out[3];
    send_word(int'(DIR_NORTH), 32'hF00D);
    tick(4);
    chk(cnt_out[1] == b1 + 1, "R8", "sibling gets word", cnt_out[1] - b1, 1);
    chk(cnt_out[3] == b2, "R8", "protected port silent", cnt_out[3] - b2, 0);
    chk(wall_irq == 1'b1, "R9", "flag set on violation", int'(wall_irq), 1);
    tick(6);
    chk(wall_irq == 1'b1, "R9", "flag sticky", int'(wall_irq), 1);
    m_en[1] = 1'b0;
    drive_cfg(1'b1);
    tick(1);
    chk(wall_irq == 1'b0, "R9", "config write clears flag", int'(wall_irq), 0);
    b1 = cnt_ack[DIR_NORTH];
    send_word(int'(DIR_NORTH), 32'hF11D);
    tick(4);
    chk(cnt_ack[DIR_NORTH] == b1 + 1, "R8", "walled-only word consumed", cnt_ack[DIR_NORTH] - b1, 1);
    chk(cnt_out[3] == b2, "R8", "walled-only word not sent", cnt_out[3] - b2, 0);
    chk(wall_irq == 1'b1, "R9", "flag set again", int'(wall_irq), 1);

    // R10/R11: three words parked on an unrouted input
    clear_model();
    drive_cfg(1'b1);
    b1 = cnt_ack[DIR_SOUTH]; b2 = cnt_out[DIR_LOCAL];
    for (int k = 0; k < 3; k++) send_word(int'(DIR_SOUTH), 32'h5500 + k);
    tick(6);
    chk(cnt_ack[DIR_SOUTH] == b1, "R11", "unrouted words not acked", cnt_ack[DIR_SOUTH] - b1, 0);
    for (int k = 0; k < 3; k++) exp_q[DIR_LOCAL].push_back(32'h5500 + k);
    m_src[DIR_LOCAL] = int'(DIR_SOUTH); m_en[DIR_LOCAL] = 1'b1;
    drive_cfg(1'b1);
    tick(8);
    chk(cnt_out[DIR_LOCAL] == b2 + 3, "R10", "three buffered words delivered", cnt_out[DIR_LOCAL] - b2, 3);
    chk(cnt_ack[DIR_SOUTH] == b1 + 3, "R7", "acks for released words", cnt_ack[DIR_SOUTH] - b1, 3);

    for (int o = 0; o < NP; o++)
      chk(exp_q[o].size() == 0, "R3", $sformatf("out%0d leftover expected words", o), exp_q[o].size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule